// File: doc/BRIEF.md
# Input Pulse Delay Filter

This block removes short pulses from four asynchronous input lines before they reach input-capture logic. Each line passes through its own two-flop synchronizer. A per-channel counter then runs for as long as the synchronized value differs from the filtered level. The filtered level takes the new value only when that difference has lasted a full programmed delay. When a transition is accepted, the channel raises a one-cycle strobe, rising or falling, toward the capture stage.

All four channels share one 3-bit delay selection. Each channel still keeps its own counter and its own filtered level. Selection zero bypasses the counting, so synchronized edges reach the output one cycle after the synchronizer. A raw pulse shorter than the delay is always dropped. A pulse lasting exactly the delay, counted in sampled clock cycles, always passes. Raw pulses whose length falls between those two values may go either way, depending on where their edges land relative to the sampling clock edges.

Top module: `pulse_delay_filter`

## Requirements
- R1: A raw input change passes through two synchronizer flops, so it cannot reach the filtered output before the third rising clock edge; with selection 0 it reaches the output exactly on the third edge.
- R2: The delay selection encodes 0 = bypass, 1 = 256 cycles, 2 = 512, 3 = 1024, and 4 to 7 = 2048 cycles.
- R3: A raw pulse held for (delay − 1) clock cycles or fewer leaves the filtered level unchanged and produces no strobe.
- R4: A raw pulse held for at least the delay is accepted; with a nonzero delay D, the filtered level changes on rising edge D + 2 after the raw change.
- R5: If the sampled input returns to the filtered level for even one cycle, the count restarts from zero, so two partial pulses never add up.
- R6: The four channels are independent: stimulus on one channel never causes a strobe or level change on another.
- R7: An accepted 0→1 transition pulses rise_o for exactly one cycle, an accepted 1→0 transition pulses fall_o for exactly one cycle, and a channel never asserts both at once.
- R8: While reset (rst_ni low, asynchronous) is asserted, and right after it is released, all filtered levels and strobes are 0, and any count in progress is discarded.
- R9: If the delay selection is lowered while a count is in progress and the count already meets the new delay, the transition is accepted on the next rising edge.
- R10: Both directions are filtered: a low pulse shorter than the delay on a channel whose filtered level is high causes no fall strobe and no level change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | 4 | Raw asynchronous input lines, one per channel |
| dly_sel_i | input | 3 | Shared delay selection (encoding in R2) |
| filt_o | output | 4 | Filtered levels |
| rise_o | output | 4 | One-cycle strobe per channel on an accepted rising transition |
| fall_o | output | 4 | One-cycle strobe per channel on an accepted falling transition |

## Verification
Almost all internal state in this block is a counter or a level. A counter that is off by one shows up at the ports as a pulse of exactly delay or delay − 1 cycles being judged the wrong way. A counter that fails to restart, or that leaks between channels, shows up as a strobe on a pulse that should have been dropped, or on a channel that received no stimulus. Each such fault becomes visible within one delay window, at most 2050 cycles. A wrong synchronizer depth or a wrong delay decode moves the edge on which the filtered level changes. Measuring that edge count exactly therefore exposes the fault on the first accepted transition.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    // Maps the shared delay selection onto a cycle count: 0 bypasses the
    // filter, each step above it doubles the base, saturating at max_shift.
    function automatic int unsigned delay_cycles(input logic [2:0] sel,
                                                 input int unsigned base,
                                                 input int unsigned max_shift);
        int unsigned sh;
        if (sel == 3'd0) begin
            return 0;
        end
        sh = 32'(sel) - 32'd1;
        if (sh > max_shift) begin
            sh = max_shift;
        end
        return base << sh;
    endfunction

endpackage

// File: rtl/pdf_sync.sv
module pdf_sync #(
    parameter int NCH = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] raw_i,
    output logic [NCH-1:0] smp_o
);

    typedef struct packed {
        logic [NCH-1:0] meta;
        logic [NCH-1:0] stab;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_o = st_q.stab;

    // Edges seen since reset, saturating at 2; used only to arm the check.
    logic [1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd2) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R1: the sampled value is the raw input from exactly two edges back
    a_r1_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd2) |-> (smp_o == $past(raw_i, 2)));

endmodule

// File: rtl/pdf_chan.sv
module pdf_chan #(
    parameter int DW      = 12,
    parameter int MAX_DLY = 2048
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          smp_i,
    input  logic [DW-1:0] dly_i,
    output logic          lvl_o,
    output logic          rise_o,
    output logic          fall_o
);

    typedef struct packed {
        logic          lvl;
        logic          rise;
        logic          fall;
        logic [DW-1:0] cnt;
    } chan_t;

    chan_t st_d, st_q;
    logic  bypass;
    logic  reached;

    assign bypass  = (dly_i == '0);
    assign reached = (st_q.cnt >= (dly_i - DW'(1)));

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (smp_i == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (bypass || reached) begin
            st_d.lvl  = smp_i;
            st_d.cnt  = '0;
            st_d.rise = smp_i;
            st_d.fall = !smp_i;
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.lvl;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

    // R5: a sample matching the filtered level clears the count
    a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_i == st_q.lvl) |=> (st_q.cnt == '0));

    // R3: the level only ever moves to the value the synchronizer presented
    a_r3_level_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.lvl != $past(st_q.lvl)) |-> (st_q.lvl == $past(smp_i)));

    // R2: the count never exceeds the largest selectable delay
    a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(st_q.cnt) < MAX_DLY));

    // R1: bypass moves the level on the very next edge
    a_r1_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bypass && (smp_i != st_q.lvl)) |=> (st_q.lvl != $past(st_q.lvl)));

    // R7: strobes are exclusive and match the level change they report
    a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));
    a_r7_rise_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (lvl_o && !$past(lvl_o)));
    a_r7_fall_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> (!lvl_o && $past(lvl_o)));

endmodule

// File: rtl/pulse_delay_filter.sv
module pulse_delay_filter #(
    parameter int NCH       = 4,
    parameter int SEL_W     = 3,
    parameter int BASE_DLY  = 256,
    parameter int MAX_SHIFT = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NCH-1:0]   raw_i,
    input  logic [SEL_W-1:0] dly_sel_i,
    output logic [NCH-1:0]   filt_o,
    output logic [NCH-1:0]   rise_o,
    output logic [NCH-1:0]   fall_o
);

    localparam int MAX_DLY = BASE_DLY << MAX_SHIFT;
    localparam int DW      = $clog2(MAX_DLY) + 1;

    logic [NCH-1:0] smp;
    logic [DW-1:0]  dly;

    always_comb begin
        dly = DW'(pdf_pkg::delay_cycles(3'(dly_sel_i), BASE_DLY, MAX_SHIFT));
    end

    pdf_sync #(
        .NCH (NCH)
    ) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (raw_i),
        .smp_o  (smp)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pdf_chan #(
            .DW      (DW),
            .MAX_DLY (MAX_DLY)
        ) chan_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .smp_i  (smp[c]),
            .dly_i  (dly),
            .lvl_o  (filt_o[c]),
            .rise_o (rise_o[c]),
            .fall_o (fall_o[c])
        );
    end

    // R6: a channel whose raw line has been quiet since reset stays low
    a_r6_quiet_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((filt_o & ~($past(filt_o) | $past(smp))) == '0));

    // R8: reset leaves every output low on the first edge after release
    a_r8_reset_outputs: assert property (@(posedge clk_i)
        !$past(rst_ni) |-> ((filt_o == '0) && (rise_o == '0) && (fall_o == '0)));

endmodule

// File: tb/pulse_delay_filter_tb_top.sv
module pulse_delay_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] raw = '0;
    logic [2:0] sel = '0;
    logic [3:0] filt, rise, fall;

    always #2.5 clk = ~clk;

    pulse_delay_filter dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .raw_i     (raw),
        .dly_sel_i (sel),
        .filt_o    (filt),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int rc[4];
    int fc[4];
    int both_err = 0;

    always @(negedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (rise[c]) rc[c]++;
            if (fall[c]) fc[c]++;
            if (rise[c] && fall[c]) both_err++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        @(posedge clk);
        for (int c = 0; c < 4; c++) begin
            rc[c] = 0;
            fc[c] = 0;
        end
        @(negedge clk);
    endtask

    function automatic int dly_of(input int code);
        if (code == 0) return 0;
        if (code > 4) return 2048;
        return 256 << (code - 1);
    endfunction

    // Counts rising edges from a raw change until the channel reaches lvl.
    task automatic measure(input int ch, input bit lvl, output int n);
        n = 0;
        while (filt[ch] != lvl && n < 3000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    localparam int NV = 14;
    localparam int V_CODE [NV] = '{1, 1, 1, 0, 0, 2, 2, 3, 3, 4, 4, 7, 7, 1};
    localparam int V_MASK [NV] = '{1, 1, 2, 4, 8, 3, 3, 12, 5, 15, 10, 1, 1, 15};
    localparam int V_WID  [NV] = '{255, 256, 300, 1, 3, 511, 512, 1023, 1024, 2047, 2048, 2047, 2048, 10};
    localparam int V_ACC  [NV] = '{0, 1, 1, 1, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0};

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int exp;
        for (int c = 0; c < 4; c++) begin
            rc[c] = 0;
            fc[c] = 0;
        end
        // R8: reset state
        cyc(3);
        check(filt == 4'h0 && rise == 4'h0 && fall == 4'h0, "R8 reset outputs",
              int'({filt, rise, fall}), 0);
        rst_n = 1'b1;
        cyc(2);
        check(filt == 4'h0, "R8 after release", int'(filt), 0);

        // Vector table: R2 R3 R4 R6 R7
        for (int v = 0; v < NV; v++) begin
            sel = 3'(V_CODE[v]);
            raw = '0;
            cyc(4);
            clear_counts();
            raw = 4'(V_MASK[v]);
            cyc(V_WID[v]);
            raw = '0;
            cyc(dly_of(V_CODE[v]) + 10);
            for (int c = 0; c < 4; c++) begin
                exp = (V_MASK[v][c] && V_ACC[v] != 0) ? 1 : 0;
                check(rc[c] == exp, $sformatf("R4/R3/R6 rise vec%0d ch%0d", v, c), rc[c], exp);
                check(fc[c] == exp, $sformatf("R7 fall vec%0d ch%0d", v, c), fc[c], exp);
            end
            check(filt == 4'h0, $sformatf("R3 level back low vec%0d", v), int'(filt), 0);
        end

        // R1: bypass latency is exactly three edges
        sel = 3'd0;
        raw[2] = 1'b1;
        measure(2, 1'b1, n);
        check(n == 3, "R1 bypass latency", n, 3);
        raw[2] = 1'b0;
        cyc(6);

        // R4: nonzero delay latency is D + 2 edges
        sel = 3'd1;
        raw[1] = 1'b1;
        measure(1, 1'b1, n);
        check(n == 258, "R4 latency code1", n, 258);
        raw[1] = 1'b0;
        cyc(270);
        sel = 3'd2;
        raw[3] = 1'b1;
        measure(3, 1'b1, n);
        check(n == 514, "R2 latency code2", n, 514);
        raw[3] = 1'b0;
        cyc(530);

        // R5: two partial pulses separated by one low cycle
        sel = 3'd1;
        clear_counts();
        raw[0] = 1'b1;
        cyc(200);
        raw[0] = 1'b0;
        cyc(1);
        raw[0] = 1'b1;
        cyc(200);
        raw[0] = 1'b0;
        cyc(270);
        check(rc[0] == 0 && filt[0] == 1'b0, "R5 count restarts", rc[0], 0);

        // R10: falling glitch on a high level is filtered
        raw[0] = 1'b1;
        cyc(300);
        check(filt[0] == 1'b1, "R10 level high", int'(filt[0]), 1);
        clear_counts();
        raw[0] = 1'b0;
        cyc(255);
        raw[0] = 1'b1;
        cyc(270);
        check(fc[0] == 0 && filt[0] == 1'b1, "R10 low glitch rejected", fc[0], 0);
        raw[0] = 1'b0;
        cyc(270);
        check(fc[0] == 1 && filt[0] == 1'b0, "R10 long low accepted", fc[0], 1);

        // R9: lowering the delay mid-count accepts on the next edge
        sel = 3'd4;
        raw[1] = 1'b1;
        cyc(600);
        check(filt[1] == 1'b0, "R9 still counting", int'(filt[1]), 0);
        sel = 3'd1;
        cyc(1);
        check(filt[1] == 1'b1, "R9 accepted next edge", int'(filt[1]), 1);
        raw[1] = 1'b0;
        cyc(270);

        // R8: reset mid-count discards progress
        raw[2] = 1'b1;
        cyc(100);
        rst_n = 1'b0;
        cyc(2);
        check(filt == 4'h0, "R8 reset during count", int'(filt), 0);
        rst_n = 1'b1;
        cyc(200);
        check(filt[2] == 1'b0, "R8 count discarded", int'(filt[2]), 0);
        cyc(100);
        check(filt[2] == 1'b1, "R8 counts again", int'(filt[2]), 1);
        raw[2] = 1'b0;
        cyc(270);

        // R7: strobes never overlapped on any channel
        check(both_err == 0, "R7 exclusive strobes", both_err, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule